// File: doc/BRIEF.md
# Subranging Converter Correction Pipeline

This block is the digital back end of a two-step subranging analog-to-digital converter. Each conversion clock brings a 5-bit coarse estimate and a 6-bit code for the amplified residue. The two codes overlap by one bit of range, so that small coarse-stage errors can be absorbed. The block adds them with the overlap offset taken out and forms a 10-bit offset-binary word. When the sum falls outside the code range, it pins the word to the nearest end of the scale and raises a range flag that belongs to that same sample.

The result leaves the block a fixed number of clock edges after capture, straight from a register. A run input tells the block whether the conversion clock was really running on a given edge. Any edge with the run input low means the samples held inside the pipeline are lost. A valid flag therefore drops and returns only once fresh samples have refilled every stage.

Top module: `subrange_corrector`

## Requirements
- R1: For each captured pair, the output word is the coarse code times 32, plus the fine code, minus 16, whenever that value lies in 0..1023.
- R2: A pair present before capture edge N is on `data_out` just after edge N+3, and not earlier (the word after edge N+2 still belongs to the previous sample).
- R3: The output is offset binary: coarse 16 / fine 16 gives 512 (mid-scale), coarse 0 / fine 16 gives 0, and coarse 31 / fine 47 gives 1023, all with `over_range` low.
- R4: A corrected value above 1023 (for example coarse 31 / fine 48) gives `data_out` = 1023 (all ones) with `over_range` = 1.
- R5: A corrected value below 0 (for example coarse 0 / fine 15) gives `data_out` = 0 with `over_range` = 1.
- R6: `over_range` is aligned to its own sample. The first in-range sample after an out-of-range one shows `over_range` = 0.
- R7: An edge with `clk_run` low drives `data_valid` low after that edge. `data_valid` returns high only after the fourth consecutive edge with `clk_run` high.
- R8: A synchronous active-high `rst` clears every stage. After a reset edge, `data_out` = 0, `over_range` = 0 and `data_valid` = 0, and refill then follows the same rule as R7.
- R9: `data_out`, `over_range` and `data_valid` change only on clock edges. A change on `coarse_code`, `fine_code` or `clk_run` between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; samples taken on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_run | input | 1 | High when the conversion clock is running on this edge; low marks a stop |
| coarse_code | input | 5 | Coarse quantizer code |
| fine_code | input | 6 | Residue quantizer code |
| data_out | output | 10 | Corrected offset-binary word, registered |
| over_range | output | 1 | Out-of-range flag aligned with `data_out` |
| data_valid | output | 1 | High when the pipeline holds only samples taken with the clock running |

## Verification
Directed pairs sit on both sides of each clamp edge: 1023 against 1024, and 0 against -1. Together with mid-scale, these separate a wrong offset, a wrong coarse weight, an off-by-one clamp threshold and swapped saturation codes. A single odd word inside a steady stream measures the latency exactly. An in-range sample right after an out-of-range one shows whether the flag is carried per sample or held too long. Long random streams, broken by single-edge and multi-edge run drops and a mid-stream reset, exercise refill and flush timing against a queue-based model on every clock.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  // Outcome of comparing the merged value against the code range
  typedef enum logic [1:0] {
    RANGE_OK   = 2'd0,
    RANGE_LOW  = 2'd1,
    RANGE_HIGH = 2'd2
  } range_e;

endpackage

// File: rtl/subrange_merge.sv
// Capture stage plus overlap-corrected merge stage.
module subrange_merge #(
  parameter int CW    = 5,
  parameter int FW    = 6,
  parameter int SW    = 12,
  parameter int SHIFT = 5,
  parameter int OFS   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        coarse,
  input  logic [FW-1:0]        fine,
  output logic signed [SW-1:0] sum_q
);

  logic [CW-1:0]        coarse_q;
  logic [FW-1:0]        fine_q;
  logic signed [SW-1:0] sum_d;

  // Stage 0: capture the raw codes on the sampling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      coarse_q <= coarse;
      fine_q   <= fine;
    end
  end

  // Coarse weight is one fine LSB shifted up; the overlap offset is removed
  always_comb begin
    sum_d = $signed(SW'(coarse_q) << SHIFT)
          + $signed(SW'(fine_q))
          - $signed(SW'(OFS));
  end

  // Stage 1: signed merged value, wide enough for both overshoots
  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end

endmodule

// File: rtl/subrange_clamp.sv
// Range detection and saturation stage.
module subrange_clamp
  import subrange_pkg::*;
#(
  parameter int SW = 12,
  parameter int OW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] sum,
  output logic [OW-1:0]        code_q,
  output logic                 ovr_q
);

  localparam logic signed [SW-1:0] TOP_CODE = SW'((2 ** OW) - 1);

  range_e kind;

  always_comb begin
    if (sum < 0)             kind = RANGE_LOW;
    else if (sum > TOP_CODE) kind = RANGE_HIGH;
    else                     kind = RANGE_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      case (kind)
        RANGE_LOW: begin
          code_q <= '0;
          ovr_q  <= 1'b1;
        end
        RANGE_HIGH: begin
          code_q <= '1;
          ovr_q  <= 1'b1;
        end
        default: begin
          code_q <= sum[OW-1:0];
          ovr_q  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/subrange_delay.sv
// Register line that pads the pipeline to the configured latency.
module subrange_delay #(
  parameter int W     = 11,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];

endmodule

// File: rtl/subrange_fill.sv
// Tracks pipeline refill after a clock stop or reset.
module subrange_fill #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_run,
  output logic valid_q
);

  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LAT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !clk_run) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      valid_q <= (cnt_q == FULL);
    end
  end

endmodule

// File: rtl/subrange_corrector.sv
// Digital correction back end for a two-step subranging converter.
module subrange_corrector #(
  parameter int COARSE_W    = 5,
  parameter int FINE_W      = 6,
  parameter int OUT_W       = 10,
  parameter int LATENCY     = 3,
  parameter int OVERLAP_OFS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_run,
  input  logic [COARSE_W-1:0] coarse_code,
  input  logic [FINE_W-1:0]   fine_code,
  output logic [OUT_W-1:0]    data_out,
  output logic                over_range,
  output logic                data_valid
);

  localparam int SUM_W  = COARSE_W + FINE_W + 1;
  localparam int SHIFT  = OUT_W - COARSE_W;
  localparam int TAIL   = (LATENCY > 2) ? LATENCY - 2 : 1;
  localparam int WORD_W = OUT_W + 1;

  logic signed [SUM_W-1:0] merged;
  logic [OUT_W-1:0]        clamp_code;
  logic                    clamp_ovr;
  logic [WORD_W-1:0]       tail_out;

  subrange_merge #(
    .CW   (COARSE_W),
    .FW   (FINE_W),
    .SW   (SUM_W),
    .SHIFT(SHIFT),
    .OFS  (OVERLAP_OFS)
  ) u_merge (
    .clk   (clk),
    .rst   (rst),
    .coarse(coarse_code),
    .fine  (fine_code),
    .sum_q (merged)
  );

  subrange_clamp #(
    .SW(SUM_W),
    .OW(OUT_W)
  ) u_clamp (
    .clk   (clk),
    .rst   (rst),
    .sum   (merged),
    .code_q(clamp_code),
    .ovr_q (clamp_ovr)
  );

  subrange_delay #(
    .W    (WORD_W),
    .DEPTH(TAIL)
  ) u_tail (
    .clk (clk),
    .rst (rst),
    .din ({clamp_ovr, clamp_code}),
    .dout(tail_out)
  );

  subrange_fill #(
    .LAT(LATENCY)
  ) u_fill (
    .clk    (clk),
    .rst    (rst),
    .clk_run(clk_run),
    .valid_q(data_valid)
  );

  assign data_out   = tail_out[OUT_W-1:0];
  assign over_range = tail_out[OUT_W];

endmodule

// File: rtl/subrange_corrector_sva.sv
module subrange_corrector_sva #(
  parameter int OUT_W   = 10,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_run,
  input logic [OUT_W-1:0] data_out,
  input logic             over_range,
  input logic             data_valid
);

  localparam int RUN_W = $clog2(LATENCY + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LATENCY + 1);

  // Consecutive running edges since reset or the last stop
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !clk_run) run_cnt <= '0;
    else if (run_cnt != RUN_SAT) run_cnt <= run_cnt + 1'b1;
  end

  // R4 / R5: a flagged sample sits on one end of the scale
  p_clamp_ends_r4: assert property (@(posedge clk) disable iff (rst)
    over_range |-> (data_out == '0 || data_out == '1));

  // R7: a stop edge removes validity on the following cycle
  p_stop_drops_r7: assert property (@(posedge clk) disable iff (rst)
    !clk_run |=> !data_valid);

  // R7: validity only after the pipeline has been fully refilled
  p_refill_r7: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (run_cnt == RUN_SAT));

  // R8: outputs cleared by the reset edge
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (data_out == '0 && !over_range && !data_valid));

endmodule

bind subrange_corrector subrange_corrector_sva #(
  .OUT_W  (OUT_W),
  .LATENCY(LATENCY)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .clk_run   (clk_run),
  .data_out  (data_out),
  .over_range(over_range),
  .data_valid(data_valid)
);

// File: tb/tb_subrange_corrector.sv
module tb_subrange_corrector;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_run = 1'b0;
  logic [4:0] coarse = '0;
  logic [5:0] fine = '0;
  logic [9:0] data_out;
  logic       over_range;
  logic       data_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  subrange_corrector dut (
    .clk        (clk),
    .rst        (rst),
    .clk_run    (clk_run),
    .coarse_code(coarse),
    .fine_code  (fine),
    .data_out   (data_out),
    .over_range (over_range),
    .data_valid (data_valid)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of expected words, run-edge counter
  int m_code[$];
  bit m_ovr[$];
  int m_good = 0;
  bit m_rst = 1'b1;

  always @(posedge clk) begin
    int v;
    if (rst) begin
      m_code.delete();
      m_ovr.delete();
      m_good = 0;
      m_rst = 1'b1;
    end else begin
      m_rst = 1'b0;
      v = int'(coarse) * 32 + int'(fine) - 16;
      if (v < 0) begin
        m_code.push_back(0); m_ovr.push_back(1'b1);
      end else if (v > 1023) begin
        m_code.push_back(1023); m_ovr.push_back(1'b1);
      end else begin
        m_code.push_back(v); m_ovr.push_back(1'b0);
      end
      if (m_code.size() > LAT + 1) begin
        void'(m_code.pop_front());
        void'(m_ovr.pop_front());
      end
      if (!clk_run) m_good = 0;
      else if (m_good <= LAT) m_good++;
    end
  end

  // Compare every cycle, away from the active edge
  bit prev_ovr = 1'b0;
  always @(negedge clk) begin
    bit ev;
    int ec;
    bit eo;
    string lbl;
    if (!finished) begin
      if (m_rst) begin
        chk("R8", data_out == 10'd0 && !over_range && !data_valid,
            int'(data_out) + 1024 * int'(over_range) + 2048 * int'(data_valid), 0);
        prev_ovr = 1'b0;
      end else begin
        ev = (m_good > LAT);
        chk("R7", data_valid == ev, int'(data_valid), int'(ev));
        if (ev) begin
          ec = m_code[0];
          eo = m_ovr[0];
          if (eo)                                   lbl = (ec == 1023) ? "R4" : "R5";
          else if (prev_ovr)                        lbl = "R6";
          else if (ec == 0 || ec == 512 || ec == 1023) lbl = "R3";
          else                                      lbl = "R1";
          chk(lbl, data_out == 10'(ec) && over_range == eo,
              int'(data_out) + 1024 * int'(over_range), ec + 1024 * int'(eo));
          prev_ovr = eo;
        end
      end
    end
  end

  task automatic drive(int c, int f, bit run);
    coarse  = 5'(c);
    fine    = 6'(f);
    clk_run = run;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Boundary and mid-scale pairs (R3, R4, R5, R6)
    drive(16, 16, 1); drive(16, 16, 1); drive(16, 16, 1); drive(16, 16, 1);
    drive(0, 16, 1);
    drive(31, 47, 1);
    drive(31, 48, 1);
    drive(16, 16, 1);
    drive(0, 15, 1);
    drive(0, 16, 1);
    drive(31, 63, 1);
    drive(0, 0, 1);
    drive(20, 5, 1);
    drive(10, 40, 1);
    drive(31, 47, 1);

    // R2: single odd word in a steady stream
    repeat (6) drive(10, 20, 1);
    coarse = 5'd20; fine = 6'd30;
    @(negedge clk);
    coarse = 5'd10; fine = 6'd20;
    chk("R2", data_out == 10'd324, int'(data_out), 324);
    @(negedge clk);
    chk("R2", data_out == 10'd324, int'(data_out), 324);
    @(negedge clk);
    chk("R2", data_out == 10'd324, int'(data_out), 324);
    @(negedge clk);
    chk("R2", data_out == 10'd654, int'(data_out), 654);
    @(negedge clk);
    chk("R2", data_out == 10'd324, int'(data_out), 324);

    // R9: input changes between edges leave outputs untouched
    begin
      logic [9:0] d0;
      logic       o0;
      logic       v0;
      d0 = data_out; o0 = over_range; v0 = data_valid;
      coarse = 5'd31; fine = 6'd63; clk_run = 1'b0;
      #2;
      chk("R9", data_out == d0 && over_range == o0 && data_valid == v0,
          int'(data_out), int'(d0));
      clk_run = 1'b1;
      @(negedge clk);
    end

    // R7: single-edge and longer stops
    drive(12, 12, 1); drive(12, 12, 0);
    repeat (6) drive(14, 33, 1);
    repeat (5) drive(3, 3, 0);
    repeat (6) drive(25, 9, 1);

    // Random stream with occasional stops
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 31), $urandom_range(0, 63), $urandom_range(0, 30) != 0);

    // R8: reset in the middle of a stream, then refill
    rst = 1'b1;
    repeat (2) drive(7, 7, 1);
    rst = 1'b0;
    for (int i = 0; i < 500; i++)
      drive($urandom_range(0, 31), $urandom_range(0, 63), $urandom_range(0, 20) != 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule